// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block watches the command pins of an SDRAM interface without driving anything. On every rising clock edge it decodes chip select, RAS#, CAS# and WE# into a command. It tracks whether each of four banks is idle or holds an open row, and it times each bank from its last ACTIVATE and from its last PRECHARGE. A command that is illegal in the current bank state, or that arrives too soon after an earlier command to the same bank, raises an error.

Errors fall into six classes, and each class owns a sticky flag. The first error since reset or since the last clear is also recorded as a code with the bank it concerned. A free-running age counter measures the cycles since the last AUTO REFRESH. An overdue flag is raised once the refresh gap passes a configured limit. The three timing limits are sampled from configuration inputs while reset is held, so the monitor sits beside a controller and checks it against the settings that were in force at start-up.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded at the rising edge as {cs_n, ras_n, cas_n, we_n}: 0011 ACTIVATE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 AUTO REFRESH. Any pattern with cs_n high, and every other pattern, has no effect on bank state or error flags.
- R2: An ACTIVATE to a bank that already holds an open row sets err_flags[0]. The bank stays open with the new row.
- R3: A READ or WRITE to an open bank that arrives k cycles after that bank's ACTIVATE, with k below the latched tRCD, sets err_flags[1].
- R4: An ACTIVATE that arrives k cycles after a PRECHARGE which closed that bank, with k below the latched tRP, sets err_flags[2]. A bank that has not been precharged since reset never trips this check.
- R5: A READ or WRITE to an idle bank sets err_flags[3] and leaves the bank idle.
- R6: An AUTO REFRESH while any bank is open sets err_flags[4]. The recorded bank is the lowest-numbered open bank.
- R7: ref_age is 0 during reset and after an AUTO REFRESH, and otherwise rises by one per cycle. If a refresh gap of more than the latched refresh limit cycles occurs (ref_age >= limit at an edge), err_flags[5] is set.
- R8: Flags are sticky. err_code holds 1 plus the index of the first error since reset or clear, and err_bank holds its bank (0 for the overdue class). When several classes fire in one cycle, the lowest index wins. Both fields hold until cleared.
- R9: err_clr high at an edge clears flags, code and bank, and errors detected in that same cycle are dropped.
- R10: tRCD, tRP and the refresh limit are taken from the cfg inputs while rst_n is low. Changes to those inputs after reset have no effect.
- R11: Each bank keeps its own state and timers. A command to one bank neither trips nor resets the checks of another.
- R12: bank_open[i] shows whether bank i holds an open row, and bank_row holds that row in slice i, taken from addr at the ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples commands |
| rst_n | input | 1 | Synchronous active-low reset, also latches configuration |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address |
| addr | input | ADDR_W | Row/column address |
| cfg_trcd | input | CNT_W | Minimum ACTIVATE to READ/WRITE spacing in cycles |
| cfg_trp | input | CNT_W | Minimum PRECHARGE to ACTIVATE spacing in cycles |
| cfg_tref | input | REF_W | Longest allowed refresh gap in cycles |
| err_clr | input | 1 | Clears all error state |
| err_flags | output | 6 | Sticky flags, one per error class |
| err_code | output | 3 | First error class plus one, 0 when none |
| err_bank | output | BANK_W | Bank of the first recorded error |
| ref_age | output | REF_W | Cycles since the last refresh |
| bank_open | output | NUM_BANKS | Open-row indicator per bank |
| bank_row | output | NUM_BANKS*ADDR_W | Open row per bank, bank i in slice i |

## Verification
The bench sweeps the spacing from ACTIVATE to column command and from PRECHARGE to ACTIVATE across the exact threshold for every bank. A comparison off by one, such as <= in place of <, shows up as a flag one cycle early or late. The refresh gap is probed at the limit and one beyond, both after reset and after a refresh, which catches an age counter that starts at the wrong value. Two classes are forced into the same cycle to check priority and the first-error record. Errors during a clear cycle, deselected command patterns, interleaved banks and configuration changes after reset are each covered. A design that dropped the clear priority, decoded with chip select ignored, shared timers between banks or followed live configuration would set flags where none are expected.

// File: rtl/sdram_mon_pkg.sv
// Shared command encoding and error class indices for the SDRAM command monitor.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_OTHER
    } cmd_e;

    localparam int ERR_NUM      = 6;
    localparam int CODE_W       = 3;
    localparam int ERR_ACT_OPEN = 0;
    localparam int ERR_RCD      = 1;
    localparam int ERR_RP       = 2;
    localparam int ERR_IDLE_RW  = 3;
    localparam int ERR_REF_BUSY = 4;
    localparam int ERR_REF_LATE = 5;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational decode of the four command strobes into a command value.
// Assumes the strobes are already synchronous to the sampling clock.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe pattern to a command; chip select high always deselects.
    always_comb begin
        case ({cs_n, ras_n, cas_n, we_n})
            4'b0011: cmd = CMD_ACT;
            4'b0101: cmd = CMD_RD;
            4'b0100: cmd = CMD_WR;
            4'b0010: cmd = CMD_PRE;
            4'b0001: cmd = CMD_REF;
            4'b0111: cmd = CMD_NOP;
            default: cmd = cs_n ? CMD_NOP : CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// State and timing checks for one bank: open/idle, open row, cycles since
// ACTIVATE and cycles since a closing PRECHARGE. Error outputs are
// combinational for the command in the current cycle. Assumes sel is high
// only when the command addresses this bank.
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] row,
    input  logic [CNT_W-1:0]  trcd,
    input  logic [CNT_W-1:0]  trp,
    output logic              is_open,
    output logic [ADDR_W-1:0] open_row,
    output logic              err_act_open,
    output logic              err_rcd,
    output logic              err_rp,
    output logic              err_idle_rw
);

    localparam logic [CNT_W-1:0] AGE_MAX = '1;
    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    logic [CNT_W-1:0] act_age;
    logic [CNT_W-1:0] pre_age;
    logic             do_act;
    logic             do_pre;
    logic             do_rw;

    // Qualify the decoded command with the bank select.
    always_comb begin
        do_act = sel && (cmd == CMD_ACT);
        do_pre = sel && (cmd == CMD_PRE);
        do_rw  = sel && ((cmd == CMD_RD) || (cmd == CMD_WR));
    end

    // Protocol checks against the state held before this edge.
    always_comb begin
        err_act_open = do_act && is_open;
        err_rp       = do_act && (pre_age < trp);
        err_idle_rw  = do_rw && !is_open;
        err_rcd      = do_rw && is_open && (act_age < trcd);
    end

    // Open/idle state and open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (do_act) begin
            is_open  <= 1'b1;
            open_row <= row;
        end else if (do_pre) begin
            is_open  <= 1'b0;
        end
    end

    // Saturating cycle count since the last ACTIVATE.
    always_ff @(posedge clk) begin
        if (!rst_n)                 act_age <= '0;
        else if (do_act)            act_age <= AGE_ONE;
        else if (act_age != AGE_MAX) act_age <= act_age + AGE_ONE;
    end

    // Saturating cycle count since a PRECHARGE that closed the bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pre_age <= AGE_MAX;
        else if (do_pre && is_open) pre_age <= AGE_ONE;
        else if (pre_age != AGE_MAX) pre_age <= pre_age + AGE_ONE;
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
// Counts cycles since the last AUTO REFRESH (reset counts as one) and flags
// when the gap would exceed the limit. Saturates at the counter maximum.
module sdram_refresh_timer #(
    parameter int REF_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_hit,
    input  logic [REF_W-1:0] limit,
    output logic [REF_W-1:0] age,
    output logic             late
);

    localparam logic [REF_W-1:0] AGE_MAX = '1;

    // Overdue when this edge closes a gap longer than the limit.
    assign late = (age >= limit);

    // Age counter, cleared by a refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= '0;
        else if (ref_hit)        age <= '0;
        else if (age != AGE_MAX) age <= age + REF_W'(1);
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
// Passive SDRAM command protocol monitor. Decodes commands, tracks each bank,
// checks ordering and spacing, and records sticky errors. Timing limits are
// latched from cfg_* while rst_n is low. Assumes one command per cycle.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int CNT_W     = 4,
    parameter int REF_W     = 20,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           bank,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [CNT_W-1:0]            cfg_trcd,
    input  logic [CNT_W-1:0]            cfg_trp,
    input  logic [REF_W-1:0]            cfg_tref,
    input  logic                        err_clr,
    output logic [ERR_NUM-1:0]          err_flags,
    output logic [CODE_W-1:0]           err_code,
    output logic [BANK_W-1:0]           err_bank,
    output logic [REF_W-1:0]            ref_age,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_row
);

    cmd_e                 cmd;
    logic [CNT_W-1:0]     trcd_q;
    logic [CNT_W-1:0]     trp_q;
    logic [REF_W-1:0]     tref_q;
    logic [NUM_BANKS-1:0] b_act_open;
    logic [NUM_BANKS-1:0] b_rcd;
    logic [NUM_BANKS-1:0] b_rp;
    logic [NUM_BANKS-1:0] b_idle_rw;
    logic                 ref_late;
    logic [ERR_NUM-1:0]   err_now;
    logic [BANK_W-1:0]    busy_bank;
    logic [CODE_W-1:0]    first_code;
    logic [BANK_W-1:0]    first_bank;

    // Capture the timing limits while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trcd_q <= cfg_trcd;
            trp_q  <= cfg_trp;
            tref_q <= cfg_tref;
        end
    end

    sdram_cmd_decode dec_i (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        sdram_bank_tracker #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) trk_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (bank == BANK_W'(gi)),
            .cmd          (cmd),
            .row          (addr),
            .trcd         (trcd_q),
            .trp          (trp_q),
            .is_open      (bank_open[gi]),
            .open_row     (bank_row[gi*ADDR_W +: ADDR_W]),
            .err_act_open (b_act_open[gi]),
            .err_rcd      (b_rcd[gi]),
            .err_rp       (b_rp[gi]),
            .err_idle_rw  (b_idle_rw[gi])
        );
    end

    sdram_refresh_timer #(
        .REF_W (REF_W)
    ) ref_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_hit (cmd == CMD_REF),
        .limit   (tref_q),
        .age     (ref_age),
        .late    (ref_late)
    );

    // Gather this cycle's error classes.
    always_comb begin
        err_now               = '0;
        err_now[ERR_ACT_OPEN] = |b_act_open;
        err_now[ERR_RCD]      = |b_rcd;
        err_now[ERR_RP]       = |b_rp;
        err_now[ERR_IDLE_RW]  = |b_idle_rw;
        err_now[ERR_REF_BUSY] = (cmd == CMD_REF) && (|bank_open);
        err_now[ERR_REF_LATE] = ref_late;
    end

    // Lowest-numbered open bank, reported for refresh-while-busy.
    always_comb begin
        busy_bank = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_open[i]) busy_bank = BANK_W'(i);
        end
    end

    // Pick the lowest-index error class and its bank.
    always_comb begin
        first_code = '0;
        for (int i = ERR_NUM - 1; i >= 0; i--) begin
            if (err_now[i]) first_code = CODE_W'(i + 1);
        end
        if (first_code == CODE_W'(ERR_REF_BUSY + 1))      first_bank = busy_bank;
        else if (first_code == CODE_W'(ERR_REF_LATE + 1)) first_bank = '0;
        else                                              first_bank = bank;
    end

    // Sticky flags and first-error record; clear wins over new errors.
    always_ff @(posedge clk) begin
        if (!rst_n || err_clr) begin
            err_flags <= '0;
            err_code  <= '0;
            err_bank  <= '0;
        end else begin
            err_flags <= err_flags | err_now;
            if (err_code == '0 && first_code != '0) begin
                err_code <= first_code;
                err_bank <= first_bank;
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
// Property checker for the SDRAM command monitor, attached by bind.
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int REF_W     = 20,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BANK_W-1:0]    bank,
    input logic                 err_clr,
    input logic [ERR_NUM-1:0]   err_flags,
    input logic [CODE_W-1:0]    err_code,
    input logic [BANK_W-1:0]    err_bank,
    input logic [REF_W-1:0]     ref_age,
    input logic [NUM_BANKS-1:0] bank_open
);

    logic is_act;
    logic is_rw;
    logic is_ref;

    // Raw pattern decode, independent of the design's decoder.
    always_comb begin
        is_act = ({cs_n, ras_n, cas_n, we_n} == 4'b0011);
        is_rw  = ({cs_n, ras_n, cas_n} == 3'b010);
        is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
    end

    // R2
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open[bank] && !err_clr) |=> err_flags[ERR_ACT_OPEN]);

    // R5
    idle_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !bank_open[bank] && !err_clr) |=> err_flags[ERR_IDLE_RW]);

    // R6
    ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && (bank_open != '0) && !err_clr) |=> err_flags[ERR_REF_BUSY]);

    // R7
    ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> (ref_age == '0));

    // R7
    ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ref && (ref_age != '1)) |=> (ref_age == $past(ref_age) + REF_W'(1)));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_code != '0) && !err_clr) |=> ($stable(err_code) && $stable(err_bank)));

    // R8
    code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != '0) |-> err_flags[err_code - CODE_W'(1)]);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> ((err_flags == '0) && (err_code == '0) && (err_bank == '0)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NUM_BANKS (NUM_BANKS),
    .REF_W     (REF_W),
    .BANK_W    (BANK_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .bank      (bank),
    .err_clr   (err_clr),
    .err_flags (err_flags),
    .err_code  (err_code),
    .err_bank  (err_bank),
    .ref_age   (ref_age),
    .bank_open (bank_open)
);

// File: tb/sdram_cmd_monitor_tb.sv
// Self-checking bench: sweeps spacing and state corner cases on a 4-bank setup.
module sdram_cmd_monitor_tb_top;

    localparam int NB = 4;
    localparam int AW = 13;
    localparam int CW = 4;
    localparam int RW = 20;
    localparam int BW = 2;

    localparam logic [3:0] P_DES = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;

    localparam int TRCD = 3;
    localparam int TRP  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BW-1:0] bank = '0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] cfg_trcd = '0, cfg_trp = '0;
    logic [RW-1:0] cfg_tref = '0;
    logic          err_clr = 1'b0;
    logic [5:0]    err_flags;
    logic [2:0]    err_code;
    logic [BW-1:0] err_bank;
    logic [RW-1:0] ref_age;
    logic [NB-1:0] bank_open;
    logic [NB*AW-1:0] bank_row;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_cmd_monitor #(
        .NUM_BANKS (NB), .ADDR_W (AW), .CNT_W (CW), .REF_W (RW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .bank (bank), .addr (addr),
        .cfg_trcd (cfg_trcd), .cfg_trp (cfg_trp), .cfg_tref (cfg_tref),
        .err_clr (err_clr), .err_flags (err_flags), .err_code (err_code),
        .err_bank (err_bank), .ref_age (ref_age), .bank_open (bank_open),
        .bank_row (bank_row)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command for one edge; returns at the following falling edge.
    task automatic cyc(input logic [3:0] pat, input int b, input int a);
        {cs_n, ras_n, cas_n, we_n} = pat;
        bank = BW'(b);
        addr = AW'(a);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_DES;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(P_DES, 0, 0);
    endtask

    task automatic clear();
        err_clr = 1'b1;
        cyc(P_DES, 0, 0);
        err_clr = 1'b0;
        idle(4);
    endtask

    task automatic do_reset(input int trcd, input int trp, input int tref);
        rst_n = 1'b0;
        cfg_trcd = CW'(trcd);
        cfg_trp  = CW'(trp);
        cfg_tref = RW'(tref);
        idle(3);
        rst_n = 1'b1;
        // R10: scramble the live configuration after reset.
        cfg_trcd = '1;
        cfg_trp  = '1;
        cfg_tref = RW'(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(TRCD, TRP, 100000);

        // Reset state (R8, R7, R12)
        check("R8 reset flags", err_flags, 0);
        check("R8 reset code", err_code, 0);
        check("R7 reset age", ref_age, 0);
        check("R12 reset open", bank_open, 0);

        // R10: live cfg_tref=2 must not cause an overdue flag.
        idle(10);
        check("R10 latched refresh limit", err_flags, 0);
        check("R7 age counts", ref_age, 10);

        // R1: deselect and unused patterns change nothing.
        cyc(4'b1011, 1, 7);
        cyc(4'b1101, 1, 7);
        cyc(P_NOP, 1, 7);
        cyc(4'b0000, 1, 7);
        check("R1 deselect open", bank_open, 0);
        check("R1 deselect flags", err_flags, 0);

        // R3 sweep over every bank and spacing.
        for (int b = 0; b < NB; b++) begin
            for (int k = 1; k <= 5; k++) begin
                clear();
                cyc(P_REF, 0, 0);
                cyc(P_ACT, b, 100 + k);
                idle(k - 1);
                cyc((k % 2) ? P_RD : P_WR, b, 0);
                check($sformatf("R3 bank%0d k%0d flags", b, k), err_flags,
                      (k < TRCD) ? 6'b000010 : 6'b000000);
                check($sformatf("R3 bank%0d k%0d code", b, k), err_code,
                      (k < TRCD) ? 2 : 0);
                if (k < TRCD) check("R8 bank field", err_bank, b);
                check("R12 row", bank_row[b*AW +: AW], 100 + k);
                cyc(P_PRE, b, 0);
                idle(TRP);
            end
        end

        // R4 sweep.
        for (int b = 0; b < NB; b++) begin
            for (int k = 1; k <= 5; k++) begin
                clear();
                cyc(P_ACT, b, 5);
                idle(TRCD);
                cyc(P_PRE, b, 0);
                check("R12 closed", bank_open[b], 0);
                idle(k - 1);
                cyc(P_ACT, b, 6);
                check($sformatf("R4 bank%0d k%0d flags", b, k), err_flags,
                      (k < TRP) ? 6'b000100 : 6'b000000);
                cyc(P_PRE, b, 0);
                idle(TRP);
            end
        end

        // R2: ACTIVATE to an open bank; row updates.
        for (int b = 0; b < NB; b++) begin
            clear();
            cyc(P_ACT, b, 5);
            idle(TRCD);
            cyc(P_ACT, b, 9);
            check("R2 flags", err_flags, 6'b000001);
            check("R2 code", err_code, 1);
            check("R2 bank", err_bank, b);
            check("R12 new row", bank_row[b*AW +: AW], 9);
            cyc(P_PRE, b, 0);
            idle(TRP);
        end

        // R5 and first-error hold (R8).
        clear();
        cyc(P_RD, 2, 0);
        check("R5 read idle flags", err_flags, 6'b001000);
        check("R5 bank stays idle", bank_open, 0);
        cyc(P_WR, 1, 0);
        cyc(P_ACT, 0, 1);
        cyc(P_ACT, 0, 1);
        check("R8 flags accumulate", err_flags, 6'b001001);
        check("R8 first code kept", err_code, 4);
        check("R8 first bank kept", err_bank, 2);
        idle(5);
        check("R8 sticky", err_flags, 6'b001001);
        cyc(P_PRE, 0, 0);
        idle(TRP);

        // R6: refresh while banks open reports lowest open bank.
        clear();
        cyc(P_ACT, 3, 1);
        cyc(P_ACT, 1, 1);
        idle(TRCD);
        cyc(P_REF, 0, 0);
        check("R6 flags", err_flags, 6'b010000);
        check("R6 code", err_code, 5);
        check("R6 bank", err_bank, 1);
        cyc(P_PRE, 3, 0);
        cyc(P_PRE, 1, 0);
        idle(TRP);

        // R9 clear priority and R8 priority in one cycle.
        clear();
        cyc(P_ACT, 0, 2);
        idle(TRCD);
        cyc(P_PRE, 0, 0);
        err_clr = 1'b1;
        cyc(P_ACT, 0, 3);
        err_clr = 1'b0;
        check("R9 error in clear cycle dropped", err_flags, 0);
        cyc(P_ACT, 0, 4);
        check("R8 two classes", err_flags, 6'b000101);
        check("R8 lowest class wins", err_code, 1);
        cyc(P_PRE, 0, 0);
        idle(TRP);

        // R11: interleaved banks keep separate timers.
        clear();
        cyc(P_ACT, 0, 11);
        cyc(P_ACT, 1, 12);
        cyc(P_DES, 0, 0);
        cyc(P_RD, 0, 0);
        check("R11 bank0 read ok", err_flags, 0);
        cyc(P_RD, 1, 0);
        check("R11 bank1 read ok", err_flags, 0);
        check("R11 both open", bank_open, 4'b0011);
        cyc(P_PRE, 0, 0);
        cyc(P_ACT, 1, 13);
        check("R11 other bank precharge no tRP", err_flags[2], 0);
        check("R11 act open on bank1", err_flags, 6'b000001);
        cyc(P_PRE, 1, 0);
        idle(TRP);

        // R7: refresh window with limit 8.
        do_reset(TRCD, TRP, 8);
        for (int n = 1; n <= 10; n++) begin
            cyc(P_DES, 0, 0);
            check($sformatf("R7 after reset n%0d", n), err_flags[5], (n >= 9) ? 1 : 0);
        end
        check("R7 age after 10", ref_age, 10);
        check("R7 late code", err_code, 6);
        clear();
        cyc(P_REF, 0, 0);
        check("R7 age zero", ref_age, 0);
        clear();
        cyc(P_REF, 0, 0);
        idle(7);
        cyc(P_REF, 0, 0);
        check("R7 gap at limit ok", err_flags, 0);
        idle(8);
        cyc(P_REF, 0, 0);
        check("R7 gap over limit", err_flags, 6'b100000);
        check("R7 late bank", err_bank, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule